// File: doc/BRIEF.md
# Firmware Download Handshake Engine

This block receives a program image from a host processor over a byte-wide parallel port and places it in program memory. When it is started it puts a readiness code in its output register and raises an interrupt. The host then sends a word count, low byte first. After that come the image bytes, which the engine pairs into 16-bit words and writes to consecutive program-memory addresses. The first word of every image has to be the two-character header "DR". When the last word has been stored, the engine posts the readiness code a second time as an acknowledge. One cycle later it asserts a level that lets the core start running the new code.

The host can pace itself on the interrupt or poll a status byte. The status byte shows whether the input register still holds a byte the engine has not taken, and whether the output register has been read. A bad header or a zero count stops the engine in an error state. From that state it writes nothing more, sends no acknowledge and never releases the core.

Top module: `fwdl_engine`

## Requirements
- R1: While reset is asserted and after it is released, `hp_irq`, `pm_we`, `boot_run` and `dl_err` are 0 and the status byte reads 0x02.
- R2: A `start_i` pulse in the idle state loads 0xAC into the output register and raises `hp_irq` at the same clock edge.
- R3: The status byte is returned when `hp_sel`=1. Bit 0 is input-full and bit 1 is output-empty; the other bits are 0. A data-register read (`hp_cs_n`=0, `hp_rd_n`=0, `hp_sel`=0) clears `hp_irq` and sets output-empty.
- R4: A host write (`hp_cs_n`=0, `hp_wr_n`=0, `hp_sel`=0) loads the input register and sets input-full. A write made while input-full is set is ignored, and so is any write with `hp_sel`=1.
- R5: The first two bytes after start form the word count, low byte first.
- R6: Image bytes are paired little-endian (first byte in bits 7:0). Each completed word gives exactly one `pm_we` pulse, at addresses 0, 1, 2, …, wrapping modulo 2^AW.
- R7: If the first word is not 0x5244 ('D' then 'R'), the engine sets `dl_err`, writes nothing to program memory, does not post the acknowledge and never asserts `boot_run`.
- R8: A word count of zero sets `dl_err`, with no writes and no acknowledge.
- R9: After the last of N words is written, 0xAC is posted with `hp_irq` raised. `boot_run` rises exactly one cycle after `hp_irq` rises and stays high.
- R10: `pm_we` is a single-cycle pulse that occurs only while image words are arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a download from the idle state |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_sel | input | 1 | Register select: 0 data, 1 status |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_wdata | input | 8 | Byte written by the host |
| hp_rdata | output | 8 | Output register or status byte |
| hp_irq | output | 1 | Interrupt to the host |
| pm_we | output | 1 | Program-memory write strobe |
| pm_addr | output | AW | Program-memory word address |
| pm_data | output | 16 | Program-memory write data |
| boot_run | output | 1 | Releases the core to run the loaded code |
| dl_err | output | 1 | Download rejected (bad header or zero count) |

## Verification
The assertions check on every cycle the following local behaviour:
- a data read clears the interrupt, and a byte held in a full input register does not change;
- program writes appear only during the image phase, at the address that follows the word count;
- the error state stays silent;
- the run level rises only right after the acknowledge state.

Only the bench scenarios can show the end-to-end properties:
- the little-endian pairing of the count and the data;
- that a dropped extra write really leaves the image length unchanged;
- address wrap on a long image;
- that each kind of header fault ends with no write at all.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_DATA,
        ST_ACK,
        ST_RUN,
        ST_ERR
    } seq_state_e;

    localparam logic [7:0]  READY_CODE   = 8'hAC;
    localparam logic [15:0] HDR_WORD     = 16'h5244;
    localparam int          STAT_IN_FULL = 0;
    localparam int          STAT_OUT_EMP = 1;
endpackage

// File: rtl/fwdl_host_port.sv
module fwdl_host_port
    import fwdl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hp_cs_n,
    input  logic       hp_sel,
    input  logic       hp_rd_n,
    input  logic       hp_wr_n,
    input  logic [7:0] hp_wdata,
    output logic [7:0] hp_rdata,
    output logic       hp_irq,
    input  logic       take_i,
    input  logic       post_i,
    input  logic [7:0] post_byte_i,
    output logic       in_full_o,
    output logic [7:0] in_byte_o
);
    typedef struct packed {
        logic [7:0] in_byte;
        logic       in_full;
        logic [7:0] out_byte;
        logic       out_empty;
        logic       irq;
    } hp_regs_t;

    hp_regs_t   q, d;
    logic       host_wr, host_rd;
    logic [7:0] status;

    assign host_wr = !hp_cs_n && !hp_wr_n && !hp_sel;
    assign host_rd = !hp_cs_n && !hp_rd_n && !hp_sel;

    always_comb begin
        d = q;
        if (take_i) d.in_full = 1'b0;
        if (host_wr && !q.in_full) begin
            d.in_byte = hp_wdata;
            d.in_full = 1'b1;
        end
        if (host_rd) begin
            d.irq       = 1'b0;
            d.out_empty = 1'b1;
        end
        if (post_i) begin
            d.out_byte  = post_byte_i;
            d.out_empty = 1'b0;
            d.irq       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{in_byte: 8'h00, in_full: 1'b0, out_byte: 8'h00,
                   out_empty: 1'b1, irq: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status               = '0;
        status[STAT_IN_FULL] = q.in_full;
        status[STAT_OUT_EMP] = q.out_empty;
    end

    assign hp_rdata  = hp_sel ? status : q.out_byte;
    assign hp_irq    = q.irq;
    assign in_full_o = q.in_full;
    assign in_byte_o = q.in_byte;

    // R3
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !post_i) |=> (!hp_irq && hp_rdata == (hp_sel ? hp_rdata : q.out_byte) && q.out_empty));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full_o && !take_i) |=> (in_full_o && $stable(in_byte_o)));

    // R2
    post_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_i |=> (hp_irq && !q.out_empty));
endmodule

// File: rtl/fwdl_word_packer.sv
module fwdl_word_packer #(
    parameter int unsigned WORD_BYTES = 2,
    localparam int unsigned WORD_W    = 8 * WORD_BYTES,
    localparam int unsigned CNT_W     = (WORD_BYTES > 2) ? $clog2(WORD_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [7:0]        byte_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [WORD_W-9:0] lower;
        logic [CNT_W-1:0]  cnt;
    } pk_regs_t;

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BYTES - 1);

    pk_regs_t q, d;

    assign word_vld_o = take_i && (q.cnt == LAST_IDX);
    assign word_o     = {byte_i, q.lower};

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt = '0;
        end else if (take_i) begin
            if (q.cnt == LAST_IDX) begin
                d.cnt = '0;
            end else begin
                d.lower[q.cnt*8 +: 8] = byte_i;
                d.cnt                 = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6
    pair_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> (q.cnt == '0));
endmodule

// File: rtl/fwdl_seq.sv
module fwdl_seq
    import fwdl_pkg::*;
#(
    parameter int unsigned AW    = 10,
    parameter int unsigned LEN_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          in_full_i,
    input  logic [7:0]    in_byte_i,
    input  logic          word_vld_i,
    input  logic [15:0]   word_i,
    output logic          take_o,
    output logic          pk_take_o,
    output logic          pk_clr_o,
    output logic          post_o,
    output logic [7:0]    post_byte_o,
    output logic          pm_we_o,
    output logic [AW-1:0] pm_addr_o,
    output logic [15:0]   pm_data_o,
    output logic          run_o,
    output logic          err_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] words;
        logic             pm_we;
        logic [AW-1:0]    pm_addr;
        logic [15:0]      pm_data;
        logic             run;
    } seq_regs_t;

    seq_regs_t q, d;

    assign take_o    = in_full_i && (q.state == ST_LEN_LO || q.state == ST_LEN_HI
                                     || q.state == ST_DATA);
    assign pk_take_o = in_full_i && (q.state == ST_DATA);
    assign pk_clr_o  = (q.state != ST_DATA);

    always_comb begin
        d           = q;
        d.pm_we     = 1'b0;
        post_o      = 1'b0;
        post_byte_o = READY_CODE;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    post_o  = 1'b1;
                    d.words = '0;
                    d.state = ST_LEN_LO;
                end
            end
            ST_LEN_LO: begin
                if (in_full_i) begin
                    d.len[7:0] = in_byte_i;
                    d.state    = ST_LEN_HI;
                end
            end
            ST_LEN_HI: begin
                if (in_full_i) begin
                    d.len[15:8] = in_byte_i;
                    d.state     = ({in_byte_i, q.len[7:0]} == 16'h0000) ? ST_ERR : ST_DATA;
                end
            end
            ST_DATA: begin
                if (word_vld_i) begin
                    if (q.words == '0 && word_i != HDR_WORD) begin
                        d.state = ST_ERR;
                    end else begin
                        d.pm_we   = 1'b1;
                        d.pm_addr = q.words[AW-1:0];
                        d.pm_data = word_i;
                        d.words   = q.words + LEN_W'(1);
                        if (q.words + LEN_W'(1) == q.len) d.state = ST_ACK;
                    end
                end
            end
            ST_ACK: begin
                post_o  = 1'b1;
                d.state = ST_RUN;
            end
            ST_RUN: begin
                d.run = 1'b1;
            end
            default: begin
                d.state = ST_ERR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, len: '0, words: '0, pm_we: 1'b0,
                   pm_addr: '0, pm_data: '0, run: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pm_we_o   = q.pm_we;
    assign pm_addr_o = q.pm_addr;
    assign pm_data_o = q.pm_data;
    assign run_o     = q.run;
    assign err_o     = (q.state == ST_ERR);

    // R2
    announce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start_i) |=> (q.state == ST_LEN_LO));

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!run_o && !pm_we_o && !post_o));

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_LEN_HI && in_full_i && in_byte_i == 8'h00 && q.len[7:0] == 8'h00)
        |=> err_o);

    // R9
    run_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> ($past(q.state) == ST_RUN && $past(q.state, 2) == ST_ACK));

    // R10
    we_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we_o |-> (q.state == ST_DATA || q.state == ST_ACK));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we_o |-> (pm_addr_o == AW'(q.words - LEN_W'(1))));
endmodule

// File: rtl/fwdl_engine.sv
module fwdl_engine
    import fwdl_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hp_cs_n,
    input  logic          hp_sel,
    input  logic          hp_rd_n,
    input  logic          hp_wr_n,
    input  logic [7:0]    hp_wdata,
    output logic [7:0]    hp_rdata,
    output logic          hp_irq,
    output logic          pm_we,
    output logic [AW-1:0] pm_addr,
    output logic [15:0]   pm_data,
    output logic          boot_run,
    output logic          dl_err
);
    localparam int unsigned WORD_BYTES = 2;
    localparam int unsigned LEN_W      = 16;

    logic        take, pk_take, pk_clr, post, in_full, word_vld;
    logic [7:0]  post_byte, in_byte;
    logic [15:0] word;

    fwdl_host_port i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .hp_cs_n    (hp_cs_n),
        .hp_sel     (hp_sel),
        .hp_rd_n    (hp_rd_n),
        .hp_wr_n    (hp_wr_n),
        .hp_wdata   (hp_wdata),
        .hp_rdata   (hp_rdata),
        .hp_irq     (hp_irq),
        .take_i     (take),
        .post_i     (post),
        .post_byte_i(post_byte),
        .in_full_o  (in_full),
        .in_byte_o  (in_byte)
    );

    fwdl_word_packer #(.WORD_BYTES(WORD_BYTES)) i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (pk_clr),
        .take_i    (pk_take),
        .byte_i    (in_byte),
        .word_vld_o(word_vld),
        .word_o    (word)
    );

    fwdl_seq #(.AW(AW), .LEN_W(LEN_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .in_full_i  (in_full),
        .in_byte_i  (in_byte),
        .word_vld_i (word_vld),
        .word_i     (word),
        .take_o     (take),
        .pk_take_o  (pk_take),
        .pk_clr_o   (pk_clr),
        .post_o     (post),
        .post_byte_o(post_byte),
        .pm_we_o    (pm_we),
        .pm_addr_o  (pm_addr),
        .pm_data_o  (pm_data),
        .run_o      (boot_run),
        .err_o      (dl_err)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!hp_irq && !pm_we && !boot_run && !dl_err));
endmodule

// File: tb/test_fwdl_engine.sv
module test_fwdl_engine;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          hp_cs_n = 1'b1, hp_sel = 1'b0, hp_rd_n = 1'b1, hp_wr_n = 1'b1;
    logic [7:0]    hp_wdata = 8'h00;
    logic [7:0]    hp_rdata;
    logic          hp_irq, pm_we, boot_run, dl_err;
    logic [AW-1:0] pm_addr;
    logic [15:0]   pm_data;

    int checks = 0, errors = 0;
    int cyc = 0, wr_cnt = 0, irq_rise = -1, run_rise = -1;
    logic irq_prev = 1'b0, run_prev = 1'b0;
    logic [AW-1:0] wa [0:599];
    logic [15:0]   wd [0:599];

    fwdl_engine #(.AW(AW)) i_fwdl_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .hp_cs_n(hp_cs_n), .hp_sel(hp_sel), .hp_rd_n(hp_rd_n), .hp_wr_n(hp_wr_n),
        .hp_wdata(hp_wdata), .hp_rdata(hp_rdata), .hp_irq(hp_irq),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_data(pm_data),
        .boot_run(boot_run), .dl_err(dl_err)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            wr_cnt = 0; irq_rise = -1; run_rise = -1;
        end else begin
            if (pm_we) begin
                if (wr_cnt < 600) begin wa[wr_cnt] = pm_addr; wd[wr_cnt] = pm_data; end
                wr_cnt++;
            end
            if (hp_irq && !irq_prev) irq_rise = cyc;
            if (boot_run && !run_prev) run_rise = cyc;
        end
        irq_prev = hp_irq;
        run_prev = boot_run;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input int n, input int i);
        if (i == 0) return 16'h5244;
        return 16'(n * 16'h0101) ^ 16'(i * 16'h1357);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [7:0] b, input logic sel);
        @(negedge clk);
        hp_cs_n = 1'b0; hp_wr_n = 1'b0; hp_sel = sel; hp_wdata = b;
        @(negedge clk);
        hp_cs_n = 1'b1; hp_wr_n = 1'b1; hp_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_rd_data(output logic [7:0] b);
        @(negedge clk);
        hp_cs_n = 1'b0; hp_rd_n = 1'b0; hp_sel = 1'b0;
        #1 b = hp_rdata;
        @(negedge clk);
        hp_cs_n = 1'b1; hp_rd_n = 1'b1;
    endtask

    task automatic host_status(output logic [7:0] b);
        hp_sel = 1'b1; hp_cs_n = 1'b0; hp_rd_n = 1'b0;
        #1 b = hp_rdata;
        hp_sel = 1'b0; hp_cs_n = 1'b1; hp_rd_n = 1'b1;
    endtask

    task automatic begin_dl();
        logic [7:0] b;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R2", "irq after start", int'(hp_irq), 1);
        host_rd_data(b);
        chk("R2", "announce byte", int'(b), 8'hAC);
        chk("R3", "irq cleared by data read", int'(hp_irq), 0);
        host_status(b);
        chk("R3", "status after read", int'(b), 8'h02);
    endtask

    task automatic send_words(input int n, input int first);
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            w = (i == 0) ? 16'(first) : word_of(n, i);
            host_wr(w[7:0], 1'b0);
            host_wr(w[15:8], 1'b0);
        end
    endtask

    task automatic check_ok(input int n);
        logic [7:0] b;
        repeat (4) @(negedge clk);
        chk("R6", "write count", wr_cnt, n);
        for (int i = 0; i < n && i < 600; i++) begin
            chk("R6", "address", int'(wa[i]), i % (1 << AW));
            chk("R6", "data", int'(wd[i]), int'(word_of(n, i)));
        end
        chk("R9", "ack irq", int'(hp_irq), 1);
        chk("R9", "run one cycle after irq", run_rise - irq_rise, 1);
        chk("R9", "run level", int'(boot_run), 1);
        chk("R7", "no error", int'(dl_err), 0);
        host_rd_data(b);
        chk("R9", "ack byte", int'(b), 8'hAC);
        repeat (3) @(negedge clk);
        chk("R10", "no extra writes", wr_cnt, n);
        chk("R9", "run held", int'(boot_run), 1);
    endtask

    task automatic check_fail(input string req);
        repeat (6) @(negedge clk);
        chk(req, "error flag", int'(dl_err), 1);
        chk(req, "no writes", wr_cnt, 0);
        chk(req, "no ack irq", int'(hp_irq), 0);
        chk(req, "no run", int'(boot_run), 0);
    endtask

    task automatic good_case(input int n);
        do_reset();
        begin_dl();
        host_wr(8'(n), 1'b0);       // R5 low byte first
        host_wr(8'(n >> 8), 1'b0);
        send_words(n, 16'h5244);
        check_ok(n);
    endtask

    initial begin
        logic [7:0] b;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1", "irq in reset", int'(hp_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "irq", int'(hp_irq), 0);
        chk("R1", "pm_we", int'(pm_we), 0);
        chk("R1", "run", int'(boot_run), 0);
        chk("R1", "err", int'(dl_err), 0);
        host_status(b);
        chk("R1", "status", int'(b), 8'h02);

        // Sweep of short images, plus a long one checking count high byte and wrap
        for (int n = 1; n <= 5; n++) good_case(n);
        good_case(258);

        // R4: full input register drops writes; status-select writes ignored
        do_reset();
        host_wr(8'h03, 1'b0);
        host_status(b);
        chk("R4", "input full status", int'(b), 8'h03);
        host_wr(8'h99, 1'b0);
        host_wr(8'h55, 1'b1);
        begin_dl();
        host_wr(8'h00, 1'b0);
        send_words(3, 16'h5244);
        check_ok(3);

        // R7: swapped header characters
        do_reset(); begin_dl();
        host_wr(8'h02, 1'b0); host_wr(8'h00, 1'b0);
        send_words(1, 16'h4452);
        check_fail("R7");

        // R7: wrong second character
        do_reset(); begin_dl();
        host_wr(8'h03, 1'b0); host_wr(8'h00, 1'b0);
        send_words(1, 16'h5344);
        check_fail("R7");

        // R8: zero word count
        do_reset(); begin_dl();
        host_wr(8'h00, 1'b0); host_wr(8'h00, 1'b0);
        check_fail("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule